// File: doc/BRIEF.md
# SMBus Clock-Configuration Register Slave

This block is a serial-bus slave that holds the byte-wide configuration registers of a clock generator. A host reaches it over the two-wire SMBus with byte or block transfers, and the block presents the stored fields as plain output levels: one enable bit for each clock output, one free-run/stoppable select for each stoppable output, and a 3-bit drive-strength code. The block samples SCL and SDA with its own system clock. It pulls SDA low through an open-drain output and never stretches SCL.

The command byte that follows the address selects the starting register and the transfer type. A block transfer carries a byte count, and a block read is capped by a programmable limit register. Because of that cap, registers above the default limit can only be read in a block after the host raises the limit. A single-byte read has no cap. A start or stop condition that cuts a data byte short leaves every register as it was.

Top module: `smbusCfgSlave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits are 0x69 (0xD2 to write, 0xD3 to read). On any other address it drives no ACK and no data, and it ignores the rest of that frame.
- R2: Byte write: a command byte with bit 7 = 1 carries the register offset in bits 6:0. The next data byte is written to that offset.
- R3: Byte read: a command byte with bit 7 = 1 is followed by a repeated start and the read address. The slave then returns the register at that offset, MSB first.
- R4: Block write: a command byte with bit 7 = 0 gives the start offset. The first data byte is a count N. The next N bytes go to consecutive offsets. Further bytes are acknowledged but change nothing.
- R5: Block read: the slave first returns a count C, equal to the limit minus the start offset, or 0 when the offset is at or above the limit. It then returns C registers from consecutive offsets. Every byte after those reads 0xFF, because SDA is released.
- R6: The byte-count limit is the register at offset 0x02 and resets to 16. Register 0x11 therefore appears in a block read only after the limit is raised above 0x11.
- R7: Offset 0x00 bit i drives outEnable[i], where 1 means the output is enabled and 0 means it is disabled. The reset value is 0xFF.
- R8: Offset 0x01 bits 5:0 drive stopSel, where 0 means free running and 1 means stoppable. The reset value is 0x00. Bits 7:6 are reserved.
- R9: Offset 0x11 bits 2:0 drive driveCode. During reset this field loads 3'b101 when wirelessMode is low and 3'b111 when it is high. Bits 7:3 are reserved.
- R10: Writes to reserved bits and to unmapped offsets have no effect, and those bits read back as 0.
- R11: A stop, or a repeated start, before the eighth bit of a data byte leaves all registers unchanged. After a repeated start, the slave is ready for a new address byte.
- R12: The slave changes its SDA pull-down only while SCL is low, and it never pulls SDA down while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Synchronous active-low reset |
| wirelessMode | input | 1 | Strap that picks the drive-code reset value |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain) |
| outEnable | output | 8 | Per-output enable, 1 = enabled |
| stopSel | output | 6 | Per-output select, 1 = stoppable, 0 = free running |
| driveCode | output | 3 | Drive-strength code |

## Verification
The in-RTL assertions check four things on every cycle:
- the SDA pull-down rises only while SCL is low, and is off while idle or ignoring a frame;
- each write strobe lasts exactly one cycle;
- no register moves without a write strobe.

The bench scenarios cover what only whole frames can show:
- byte and block data landing at the right offsets;
- reserved-bit masking;
- the limit-capped block-read count and the 0xFF tail;
- NACK of a foreign address;
- aborted bytes leaving the registers untouched;
- the strap-dependent drive-code reset value.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

  // Strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       wrEn;
    logic [6:0] wrAddr;
    logic [7:0] wrData;
    logic [6:0] rdAddr;
  } regStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_WCOUNT,
    S_WDATA,
    S_RDATA,
    S_IGNORE
  } busState_t;

endpackage

// File: rtl/smbusCfgCtl.sv
module smbusCfgCtl
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  input  logic [7:0] readLimit,
  output regStrobe_t strobe,
  output logic       sdaDriveLow
);

  localparam int SYNC_LEN = 3;

  logic [SYNC_LEN-1:0] sclSh, sdaSh;
  logic sclS, sclP, sdaS, sdaP;
  logic sclRise, sclFall, startSeen, stopSeen;

  busState_t  state;
  logic [7:0] shiftReg;
  logic [3:0] bitCnt;
  logic       ackPhase, txMode, byteMode, needCount;
  logic [6:0] offset;
  logic [7:0] cntLeft;
  logic       sdaLow;
  logic       wrPulse;
  logic [6:0] wrAddrQ;
  logic [7:0] wrDataQ;
  logic [7:0] countVal;

  assign sclS = sclSh[SYNC_LEN-2];
  assign sclP = sclSh[SYNC_LEN-1];
  assign sdaS = sdaSh[SYNC_LEN-2];
  assign sdaP = sdaSh[SYNC_LEN-1];

  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startSeen = sclS & sclP & sdaP & ~sdaS;
  assign stopSeen  = sclS & sclP & ~sdaP & sdaS;

  assign countVal = (readLimit > {1'b0, offset}) ? (readLimit - {1'b0, offset}) : 8'd0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh     <= '1;
      sdaSh     <= '1;
      state     <= S_IDLE;
      shiftReg  <= '0;
      bitCnt    <= '0;
      ackPhase  <= 1'b0;
      txMode    <= 1'b0;
      byteMode  <= 1'b0;
      needCount <= 1'b0;
      offset    <= '0;
      cntLeft   <= '0;
      sdaLow    <= 1'b0;
      wrPulse   <= 1'b0;
      wrAddrQ   <= '0;
      wrDataQ   <= '0;
    end else begin
      sclSh   <= {sclSh[SYNC_LEN-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_LEN-2:0], sdaIn};
      wrPulse <= 1'b0;
      if (startSeen) begin
        state    <= S_ADDR;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        txMode   <= 1'b0;
        sdaLow   <= 1'b0;
      end else if (stopSeen) begin
        state    <= S_IDLE;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        txMode   <= 1'b0;
        sdaLow   <= 1'b0;
      end else if (state != S_IDLE) begin
        if (sclRise) begin
          if (!ackPhase) begin
            bitCnt <= bitCnt + 4'd1;
            if (!txMode) shiftReg <= {shiftReg[6:0], sdaS};
          end else if (txMode && sdaS) begin
            state <= S_IGNORE;  // host NACK ends the read
          end
        end else if (sclFall) begin
          if (ackPhase) begin
            ackPhase <= 1'b0;
            bitCnt   <= '0;
            if (state == S_RDATA) begin
              txMode <= 1'b1;
              if (needCount) begin
                shiftReg  <= countVal;
                sdaLow    <= ~countVal[7];
                cntLeft   <= countVal;
                needCount <= 1'b0;
              end else if (cntLeft != 8'd0) begin
                shiftReg <= rdData;
                sdaLow   <= ~rdData[7];
                offset   <= offset + 7'd1;
                cntLeft  <= cntLeft - 8'd1;
              end else begin
                shiftReg <= 8'hFF;
                sdaLow   <= 1'b0;
              end
            end else begin
              txMode <= 1'b0;
              sdaLow <= 1'b0;
            end
          end else if (bitCnt == 4'd8) begin
            ackPhase <= 1'b1;
            if (txMode) begin
              sdaLow <= 1'b0;
            end else begin
              case (state)
                S_ADDR: begin
                  if (shiftReg[7:1] == SLAVE_ADDR) begin
                    sdaLow <= 1'b1;
                    if (shiftReg[0]) begin
                      state     <= S_RDATA;
                      needCount <= ~byteMode;
                      cntLeft   <= 8'd1;
                    end else begin
                      state <= S_CMD;
                    end
                  end else begin
                    sdaLow <= 1'b0;
                    state  <= S_IGNORE;
                  end
                end
                S_CMD: begin
                  sdaLow   <= 1'b1;
                  byteMode <= shiftReg[7];
                  offset   <= shiftReg[6:0];
                  if (shiftReg[7]) begin
                    state   <= S_WDATA;
                    cntLeft <= 8'd1;
                  end else begin
                    state <= S_WCOUNT;
                  end
                end
                S_WCOUNT: begin
                  sdaLow  <= 1'b1;
                  cntLeft <= shiftReg;
                  state   <= S_WDATA;
                end
                S_WDATA: begin
                  sdaLow <= 1'b1;
                  if (cntLeft != 8'd0) begin
                    wrPulse <= 1'b1;
                    wrAddrQ <= offset;
                    wrDataQ <= shiftReg;
                    offset  <= offset + 7'd1;
                    cntLeft <= cntLeft - 8'd1;
                  end
                end
                default: sdaLow <= 1'b0;
              endcase
            end
          end else if (txMode && bitCnt != 4'd0) begin
            shiftReg <= {shiftReg[6:0], 1'b0};
            sdaLow   <= ~shiftReg[6];
          end
        end
      end
    end
  end

  always_comb begin
    strobe.wrEn   = wrPulse;
    strobe.wrAddr = wrAddrQ;
    strobe.wrData = wrDataQ;
    strobe.rdAddr = offset;
  end

  assign sdaDriveLow = sdaLow;

  // R12: pull-down only starts while SCL is low
  assert_sda_edge_scl_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLow) |-> !sclS);

  // R12: bus released while idle
  assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaLow);

  // R1: nothing driven on a frame being ignored
  assert_no_drive_when_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IGNORE) |-> !sdaLow);

  // R4: one strobe per accepted data byte
  assert_single_write_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> !strobe.wrEn);

endmodule

// File: rtl/cfgRegBank.sv
module cfgRegBank
  import smbus_cfg_pkg::*;
#(
  parameter int         NUM_EN       = 8,
  parameter int         NUM_STOP     = 6,
  parameter int         DRIVE_W      = 3,
  parameter int         EN_OFS       = 0,
  parameter int         STOP_OFS     = 1,
  parameter int         LIMIT_OFS    = 2,
  parameter int         DRIVE_OFS    = 17,
  parameter int         LIMIT_INIT   = 16,
  parameter logic [2:0] DRIVE_NORMAL = 3'b101,
  parameter logic [2:0] DRIVE_QUIET  = 3'b111
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wirelessMode,
  input  regStrobe_t          strobe,
  output logic [7:0]          rdData,
  output logic [7:0]          readLimit,
  output logic [NUM_EN-1:0]   outEnable,
  output logic [NUM_STOP-1:0] stopSel,
  output logic [DRIVE_W-1:0]  driveCode
);

  localparam logic [6:0] EN_A    = 7'(EN_OFS);
  localparam logic [6:0] STOP_A  = 7'(STOP_OFS);
  localparam logic [6:0] LIMIT_A = 7'(LIMIT_OFS);
  localparam logic [6:0] DRIVE_A = 7'(DRIVE_OFS);

  logic [NUM_EN-1:0]   enReg;
  logic [NUM_STOP-1:0] stopReg;
  logic [7:0]          limitReg;
  logic [DRIVE_W-1:0]  driveReg;

  for (genvar i = 0; i < NUM_EN; i++) begin : g_enBit
    always_ff @(posedge clk) begin
      if (!rstN)                                        enReg[i] <= 1'b1;
      else if (strobe.wrEn && strobe.wrAddr == EN_A)    enReg[i] <= strobe.wrData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopReg  <= '0;
      limitReg <= 8'(LIMIT_INIT);
      driveReg <= wirelessMode ? DRIVE_W'(DRIVE_QUIET) : DRIVE_W'(DRIVE_NORMAL);
    end else if (strobe.wrEn) begin
      if (strobe.wrAddr == STOP_A)  stopReg  <= strobe.wrData[NUM_STOP-1:0];
      if (strobe.wrAddr == LIMIT_A) limitReg <= strobe.wrData;
      if (strobe.wrAddr == DRIVE_A) driveReg <= strobe.wrData[DRIVE_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdAddr)
      EN_A:    rdData[NUM_EN-1:0]   = enReg;
      STOP_A:  rdData[NUM_STOP-1:0] = stopReg;
      LIMIT_A: rdData               = limitReg;
      DRIVE_A: rdData[DRIVE_W-1:0]  = driveReg;
      default: rdData = '0;
    endcase
  end

  assign readLimit = limitReg;
  assign outEnable = enReg;
  assign stopSel   = stopReg;
  assign driveCode = driveReg;

  // R11: registers move only on a write strobe
  assert_regs_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> ($stable(enReg) && $stable(stopReg) && $stable(limitReg) && $stable(driveReg)));

endmodule

// File: rtl/smbusCfgSlave.sv
module smbusCfgSlave
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NUM_EN     = 8,
  parameter int         NUM_STOP   = 6,
  parameter int         DRIVE_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wirelessMode,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaDriveLow,
  output logic [NUM_EN-1:0]   outEnable,
  output logic [NUM_STOP-1:0] stopSel,
  output logic [DRIVE_W-1:0]  driveCode
);

  regStrobe_t strobe;
  logic [7:0] rdData;
  logic [7:0] readLimit;

  smbusCfgCtl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .rdData     (rdData),
    .readLimit  (readLimit),
    .strobe     (strobe),
    .sdaDriveLow(sdaDriveLow)
  );

  cfgRegBank #(
    .NUM_EN  (NUM_EN),
    .NUM_STOP(NUM_STOP),
    .DRIVE_W (DRIVE_W)
  ) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .wirelessMode(wirelessMode),
    .strobe      (strobe),
    .rdData      (rdData),
    .readLimit   (readLimit),
    .outEnable   (outEnable),
    .stopSel     (stopSel),
    .driveCode   (driveCode)
  );

endmodule

// File: tb/test_smbusCfgSlave.sv
module test_smbusCfgSlave;

  localparam int H = 8;  // clocks per SCL half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wirelessMode = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaDriveLow;
  logic [7:0] outEnable;
  logic [5:0] stopSel;
  logic [2:0] driveCode;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rdBuf [0:7];
  logic [7:0] wrBuf [0:7];

  always #10 clk = ~clk;  // 50 MHz

  assign sdaLine = sdaM & ~sdaDriveLow;

  smbusCfgSlave i_smbusCfgSlave (
    .clk(clk), .rstN(rstN), .wirelessMode(wirelessMode),
    .sclIn(sclM), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .outEnable(outEnable), .stopSel(stopSel), .driveCode(driveCode)
  );

  // {offset, written byte, expected byte read back}
  localparam logic [22:0] VEC [0:6] = '{
    {7'h00, 8'hA5, 8'hA5},
    {7'h01, 8'hFF, 8'h3F},
    {7'h11, 8'hFA, 8'h02},
    {7'h02, 8'h12, 8'h12},
    {7'h05, 8'h77, 8'h00},
    {7'h11, 8'h06, 8'h06},
    {7'h02, 8'h10, 8'h10}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic startC();
    sdaM = 1'b1; wt(H); sclM = 1'b1; wt(H); sdaM = 1'b0; wt(H); sclM = 1'b0; wt(H);
  endtask

  task automatic stopC();
    sdaM = 1'b0; wt(H); sclM = 1'b1; wt(H); sdaM = 1'b1; wt(H);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; wt(H); sclM = 1'b1; wt(H); sclM = 1'b0; wt(2);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; wt(H); sclM = 1'b1; wt(H/2);
    ack = ~sdaLine;
    wt(H/2); sclM = 1'b0; wt(2);
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; wt(H); sclM = 1'b1; wt(H/2);
      v[i] = sdaLine;
      wt(H/2); sclM = 1'b0; wt(2);
    end
    sendBit(~ackIt);
  endtask

  task automatic byteWrite(input logic [6:0] off, input logic [7:0] val);
    logic a;
    startC(); writeByte(8'hD2, a); writeByte({1'b1, off}, a); writeByte(val, a); stopC();
  endtask

  task automatic byteRead(input logic [6:0] off, output logic [7:0] v);
    logic a;
    startC(); writeByte(8'hD2, a); writeByte({1'b1, off}, a);
    startC(); writeByte(8'hD3, a); readByte(1'b0, v); stopC();
  endtask

  task automatic blockWrite(input logic [6:0] off, input logic [7:0] cnt, input int n);
    logic a;
    startC(); writeByte(8'hD2, a); writeByte({1'b0, off}, a); writeByte(cnt, a);
    for (int i = 0; i < n; i++) writeByte(wrBuf[i], a);
    stopC();
  endtask

  task automatic blockRead(input logic [6:0] off, input int n);
    logic a;
    logic [7:0] v;
    startC(); writeByte(8'hD2, a); writeByte({1'b0, off}, a);
    startC(); writeByte(8'hD3, a);
    for (int i = 0; i < n; i++) begin
      readByte(i != n - 1, v);
      rdBuf[i] = v;
    end
    stopC();
  endtask

  function automatic string reqOf(input logic [6:0] off);
    case (off)
      7'h00:   return "R7";
      7'h01:   return "R8";
      7'h02:   return "R6";
      7'h11:   return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic a;
    wt(5); rstN = 1'b1; wt(5);

    // reset state: R7 R8 R9 R12, limit R6
    check("R7 reset enables", outEnable, 8'hFF);
    check("R8 reset stop selects", {2'b00, stopSel}, 8'h00);
    check("R9 reset drive normal", {5'd0, driveCode}, 8'h05);
    check("R12 idle SDA released", {7'd0, sdaDriveLow}, 8'h00);
    byteRead(7'h02, v);
    check("R6 reset limit", v, 8'h10);

    // table walk: byte write (R2) then byte read (R3)
    for (int k = 0; k < 7; k++) begin
      byteWrite(VEC[k][22:16], VEC[k][15:8]);
      byteRead(VEC[k][22:16], v);
      check({"R2/R3 ", reqOf(VEC[k][22:16])}, v, VEC[k][7:0]);
    end
    check("R7 enable port", outEnable, 8'hA5);
    check("R8 stop port reserved masked", {2'b00, stopSel}, 8'h3F);
    check("R9 drive port", {5'd0, driveCode}, 8'h06);

    // R1: own address acknowledged, foreign one not
    startC(); writeByte(8'hD2, a);
    check("R1 own address ACK", {7'd0, a}, 8'h01);
    writeByte(8'h80, a); writeByte(8'h33, a); stopC();
    check("R2 byte write port", outEnable, 8'h33);
    startC(); writeByte(8'hA4, a);
    check("R1 foreign address NACK", {7'd0, a}, 8'h00);
    writeByte(8'h80, a); writeByte(8'h00, a); stopC();
    check("R1 foreign frame ignored", outEnable, 8'h33);

    // R4: block write with surplus byte
    wrBuf[0] = 8'h0F; wrBuf[1] = 8'h2A; wrBuf[2] = 8'h99;
    blockWrite(7'h00, 8'd2, 3);
    check("R4 block byte 0", outEnable, 8'h0F);
    check("R4 block byte 1", {2'b00, stopSel}, 8'h2A);
    byteRead(7'h02, v);
    check("R4 surplus byte ignored", v, 8'h10);

    // R5: block read with count and 0xFF tail
    blockRead(7'h00, 4);
    check("R5 count from 0", rdBuf[0], 8'h10);
    check("R5 data 0", rdBuf[1], 8'h0F);
    check("R5 data 1", rdBuf[2], 8'h2A);
    check("R5 data 2", rdBuf[3], 8'h10);
    blockRead(7'h0F, 3);
    check("R5 count from 15", rdBuf[0], 8'h01);
    check("R5 reg 15", rdBuf[1], 8'h00);
    check("R5 tail released", rdBuf[2], 8'hFF);

    // R6: reg 0x11 hidden until limit raised
    blockRead(7'h11, 2);
    check("R6 count above limit", rdBuf[0], 8'h00);
    check("R6 tail above limit", rdBuf[1], 8'hFF);
    byteWrite(7'h02, 8'h12);
    blockRead(7'h11, 2);
    check("R6 count raised", rdBuf[0], 8'h01);
    check("R6 drive via block", rdBuf[1], 8'h06);

    // R11: aborts mid-byte
    startC(); writeByte(8'hD2, a); writeByte(8'h80, a);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    stopC();
    check("R11 stop mid byte", outEnable, 8'h0F);
    startC(); writeByte(8'hD2, a); writeByte(8'h81, a);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    startC(); writeByte(8'hD2, a); writeByte(8'h81, a); writeByte(8'h15, a); stopC();
    check("R11 restart then write", {2'b00, stopSel}, 8'h15);
    check("R12 released after frames", {7'd0, sdaDriveLow}, 8'h00);

    // R9: strap-selected reset value
    wirelessMode = 1'b1; rstN = 1'b0; wt(5); rstN = 1'b1; wt(5);
    check("R9 reset drive wireless", {5'd0, driveCode}, 8'h07);
    check("R7 reset enables again", outEnable, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule